// File: doc/BRIEF.md
# Vector scalar-to-element move unit

This unit carries out the vector instructions that copy a scalar into element 0 of a destination vector register. The scalar comes either from the integer register file (XLEN bits) or from the floating-point register file (FLEN bits). The element width is 8, 16, 32 or 64 bits. The integer scalar is narrowed to the element width, or sign-extended when the element is wider than XLEN. The floating-point scalar is copied as a raw bit pattern and truncated to the element width. Only the low element-width bits of the destination change; every other bit of that register and every other register keeps its value.

The unit also decodes the whole family of move forms: vector-vector, immediate splat, integer splat, floating-point splat, and the two scalar moves. For each form it produces the operand-use flags that the register-read stage needs. The flag that requests a read of the second vector source is raised only for the vector-vector form. The two scalar moves carry a scalar-result flag that the splat forms do not. The destination registers are held in a small internal array with a combinational read port, so the results can be observed.

Each accepted request completes in one cycle. In the cycle after the request, a done pulse is output together with the registered flags, and any write is already visible on the read port.

Top module: `vsmove_unit`

## Requirements
- R1: With sew_i = 0 (8-bit elements), a scalar move from rs1_i (op_i = 3) writes rs1_i[7:0] into bits [7:0] of register vd_i.
- R2: With sew_i = 1 (16-bit elements), op_i = 3 writes rs1_i[15:0] into bits [15:0] of register vd_i.
- R3: With sew_i = 2 (32-bit elements), op_i = 3 writes all 32 bits of rs1_i into bits [31:0] of register vd_i.
- R4: With sew_i = 3 (64-bit elements), op_i = 3 writes rs1_i sign-extended to 64 bits into bits [63:0]. For example, 0xdeadbeef becomes 0xffffffffdeadbeef and 0x7fffffff becomes 0x000000007fffffff.
- R5: A scalar move changes no bit of register vd_i above the element width and no bit of any other register.
- R6: A floating-point scalar move (op_i = 5) writes the low element-width bits of fs1_i unchanged into element 0. At 64 bits the whole pattern is written; at 16 and 32 bits the upper bits of fs1_i are dropped.
- R7: use_vs2_o and use_vs1_o are high only for the vector-vector form (op_i = 0). use_vs2_o is low for the immediate (op_i = 1), integer-scalar (op_i = 2, 3) and floating-point-scalar (op_i = 4, 5) forms.
- R8: is_scalar_o is high only for op_i = 3 and op_i = 5. use_rs1_o is high only for op_i = 2 and 3. use_fs1_o is high only for op_i = 4 and 5. op_i = 6 and 7 raise no flag.
- R9: A scalar move with vl_i = 0 leaves every register unchanged.
- R10: done_o is high exactly in the cycle after a cycle with req_valid_i high. The flags are valid in that cycle, and any write is visible on rd_data_o in that same cycle.
- R11: Requests with op_i other than 3 and 5 write no register.
- R12: After reset, every register reads zero and done_o and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, one request per cycle |
| op_i | input | 3 | Move form: 0 vv, 1 vi, 2 vx, 3 scalar from rs1, 4 vf, 5 scalar from fs1 |
| sew_i | input | 2 | Element width: 0=8, 1=16, 2=32, 3=64 bits |
| vl_i | input | VL_W (6) | Active vector length |
| vd_i | input | IDX_W (3) | Destination register index |
| rs1_i | input | XLEN (32) | Integer scalar |
| fs1_i | input | FLEN (64) | Floating-point scalar bit pattern |
| rd_addr_i | input | IDX_W (3) | Read port register index |
| rd_data_o | output | VLEN (256) | Read port data, combinational |
| done_o | output | 1 | Completion pulse, one cycle after a request |
| use_vs1_o | output | 1 | First vector source is read |
| use_vs2_o | output | 1 | Second vector source is read |
| use_rs1_o | output | 1 | Integer scalar source is read |
| use_fs1_o | output | 1 | Floating-point scalar source is read |
| is_scalar_o | output | 1 | Scalar-result move (element 0 only) |

## Verification
Every result of this unit is due exactly one clock edge after the request: the done pulse, the five flags and the new contents on the read port all appear in that cycle. The driver records the cycle in which each expected item is due, and pushes the item together with the register image that its own model predicts. The monitor samples just after the falling edge. It reports a missing done pulse in the due cycle, and a done pulse for which no item is queued. Requests are spaced so that the read address stays fixed until the comparison is made. A final sweep of all registers then finds any bit that was disturbed outside element 0.

// File: rtl/vsmove_pkg.sv
package vsmove_pkg;

    typedef enum logic [2:0] {
        OP_MV_VV = 3'd0,
        OP_MV_VI = 3'd1,
        OP_MV_VX = 3'd2,
        OP_MV_SX = 3'd3,
        OP_MV_VF = 3'd4,
        OP_MV_SF = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } mv_op_e;

    typedef enum logic [1:0] {
        SEW_8  = 2'd0,
        SEW_16 = 2'd1,
        SEW_32 = 2'd2,
        SEW_64 = 2'd3
    } sew_e;

    typedef struct packed {
        logic use_vs1;
        logic use_vs2;
        logic use_rs1;
        logic use_fs1;
        logic is_scalar;
    } opflags_t;

    typedef struct packed {
        logic     done;
        opflags_t flags;
    } resp_t;

    localparam int unsigned ELEM_MAX = 64;

    function automatic logic [ELEM_MAX-1:0] sew_mask(sew_e sew);
        logic [ELEM_MAX-1:0] m;
        unique case (sew)
            SEW_8:   m = 64'h0000_0000_0000_00ff;
            SEW_16:  m = 64'h0000_0000_0000_ffff;
            SEW_32:  m = 64'h0000_0000_ffff_ffff;
            default: m = 64'hffff_ffff_ffff_ffff;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/vsmove_decode.sv
module vsmove_decode
    import vsmove_pkg::*;
(
    input  mv_op_e   op_i,
    output opflags_t flags_o
);

    always_comb begin
        flags_o = '0;
        unique case (op_i)
            OP_MV_VV: begin
                flags_o.use_vs1 = 1'b1;
                flags_o.use_vs2 = 1'b1;
            end
            OP_MV_VI: begin
                flags_o = '0;
            end
            OP_MV_VX: begin
                flags_o.use_rs1 = 1'b1;
            end
            OP_MV_SX: begin
                flags_o.use_rs1   = 1'b1;
                flags_o.is_scalar = 1'b1;
            end
            OP_MV_VF: begin
                flags_o.use_fs1 = 1'b1;
            end
            OP_MV_SF: begin
                flags_o.use_fs1   = 1'b1;
                flags_o.is_scalar = 1'b1;
            end
            default: flags_o = '0;
        endcase
    end

    // R7: a scalar-result form never asks for the second vector source
    always_comb begin
        p_vs2_excl_r7: assert (!(flags_o.use_vs2 && flags_o.is_scalar));
    end

endmodule

// File: rtl/vsmove_elem.sv
module vsmove_elem
    import vsmove_pkg::*;
#(
    parameter int unsigned XLEN = 32,
    parameter int unsigned FLEN = 64
) (
    input  mv_op_e              op_i,
    input  sew_e                sew_i,
    input  logic [XLEN-1:0]     rs1_i,
    input  logic [FLEN-1:0]     fs1_i,
    output logic [ELEM_MAX-1:0] mask_o,
    output logic [ELEM_MAX-1:0] data_o
);

    logic [ELEM_MAX-1:0] int_src;
    logic [ELEM_MAX-1:0] fp_src;

    // Integer source: sign-extend when narrower than the widest element
    if (XLEN >= ELEM_MAX) begin : g_int_wide
        assign int_src = rs1_i[ELEM_MAX-1:0];
    end else begin : g_int_narrow
        assign int_src = {{(ELEM_MAX-XLEN){rs1_i[XLEN-1]}}, rs1_i};
    end

    // Floating-point source: raw bits, zero-filled when narrower
    if (FLEN >= ELEM_MAX) begin : g_fp_wide
        assign fp_src = fs1_i[ELEM_MAX-1:0];
    end else begin : g_fp_narrow
        assign fp_src = {{(ELEM_MAX-FLEN){1'b0}}, fs1_i};
    end

    always_comb begin
        mask_o = sew_mask(sew_i);
        data_o = (op_i == OP_MV_SF) ? fp_src : int_src;
    end

endmodule

// File: rtl/vsmove_vrf.sv
module vsmove_vrf
    import vsmove_pkg::*;
#(
    parameter int unsigned NREGS = 8,
    parameter int unsigned VLEN  = 256,
    localparam int unsigned IDX_W = $clog2(NREGS)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                we_i,
    input  logic [IDX_W-1:0]    waddr_i,
    input  logic [ELEM_MAX-1:0] wmask_i,
    input  logic [ELEM_MAX-1:0] wdata_i,
    input  logic [IDX_W-1:0]    raddr_i,
    output logic [VLEN-1:0]     rdata_o
);

    logic [VLEN-1:0] mem_q [NREGS];
    logic [VLEN-1:0] mem_d [NREGS];
    logic [VLEN-1:0] mask_wide;
    logic [VLEN-1:0] data_wide;

    always_comb begin
        mask_wide = VLEN'(wmask_i);
        data_wide = VLEN'(wdata_i & wmask_i);
        for (int i = 0; i < NREGS; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we_i) begin
            mem_d[waddr_i] = (mem_q[waddr_i] & ~mask_wide) | data_wide;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < NREGS; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NREGS; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rdata_o = mem_q[raddr_i];

    // R5: without a write strobe the watched register holds its value
    p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(we_i) && $stable(raddr_i)) |-> $stable(rdata_o));

endmodule

// File: rtl/vsmove_unit.sv
module vsmove_unit
    import vsmove_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned FLEN  = 64,
    parameter int unsigned VLEN  = 256,
    parameter int unsigned NREGS = 8,
    localparam int unsigned IDX_W = $clog2(NREGS),
    localparam int unsigned VL_W  = $clog2(VLEN / 8) + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_valid_i,
    input  logic [2:0]       op_i,
    input  logic [1:0]       sew_i,
    input  logic [VL_W-1:0]  vl_i,
    input  logic [IDX_W-1:0] vd_i,
    input  logic [XLEN-1:0]  rs1_i,
    input  logic [FLEN-1:0]  fs1_i,
    input  logic [IDX_W-1:0] rd_addr_i,
    output logic [VLEN-1:0]  rd_data_o,
    output logic             done_o,
    output logic             use_vs1_o,
    output logic             use_vs2_o,
    output logic             use_rs1_o,
    output logic             use_fs1_o,
    output logic             is_scalar_o
);

    mv_op_e              op;
    sew_e                sew;
    opflags_t            dec_flags;
    logic [ELEM_MAX-1:0] elem_mask;
    logic [ELEM_MAX-1:0] elem_data;
    logic                wr_en;
    resp_t               resp_d;
    resp_t               resp_q;

    assign op  = mv_op_e'(op_i);
    assign sew = sew_e'(sew_i);

    vsmove_decode i_decode (
        .op_i    (op),
        .flags_o (dec_flags)
    );

    vsmove_elem #(
        .XLEN (XLEN),
        .FLEN (FLEN)
    ) i_elem (
        .op_i   (op),
        .sew_i  (sew),
        .rs1_i  (rs1_i),
        .fs1_i  (fs1_i),
        .mask_o (elem_mask),
        .data_o (elem_data)
    );

    vsmove_vrf #(
        .NREGS (NREGS),
        .VLEN  (VLEN)
    ) i_vrf (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (wr_en),
        .waddr_i (vd_i),
        .wmask_i (elem_mask),
        .wdata_i (elem_data),
        .raddr_i (rd_addr_i),
        .rdata_o (rd_data_o)
    );

    always_comb begin
        wr_en        = req_valid_i && dec_flags.is_scalar && (vl_i != '0);
        resp_d       = '0;
        resp_d.done  = req_valid_i;
        resp_d.flags = req_valid_i ? dec_flags : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign done_o      = resp_q.done;
    assign use_vs1_o   = resp_q.flags.use_vs1;
    assign use_vs2_o   = resp_q.flags.use_vs2;
    assign use_rs1_o   = resp_q.flags.use_rs1;
    assign use_fs1_o   = resp_q.flags.use_fs1;
    assign is_scalar_o = resp_q.flags.is_scalar;

    // Checker helpers, computed from the ports only
    logic            chk_sm;
    logic            chk_quiet;
    logic [63:0]     chk_sext;
    assign chk_sm    = (op_i == 3'd3) || (op_i == 3'd5);
    assign chk_quiet = req_valid_i && (!chk_sm || (vl_i == '0));
    assign chk_sext  = 64'($signed(rs1_i));

    // R10: done follows a request by exactly one cycle
    p_done_latency_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> done_o);
    p_done_spurious_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> !done_o);

    // R7: second vector source read only for the vector-vector form
    p_vs2_vv_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> (use_vs2_o == ($past(op_i) == 3'd0)));

    // R8: flags stay low when no request completes
    p_flags_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> !(use_vs1_o || use_vs2_o || use_rs1_o || use_fs1_o || is_scalar_o));

    // R9 and R11: no register change after a non-writing request
    p_no_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(chk_quiet) && $stable(rd_addr_i)) |-> $stable(rd_data_o));

    // R4: 64-bit element receives the sign-extended integer scalar
    p_sext64_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && op_i == 3'd3 && sew_i == 2'd3 && vl_i != '0 && rd_addr_i == vd_i)
        |=> (!$stable(rd_addr_i) || rd_data_o[63:0] == $past(chk_sext)));

endmodule

// File: tb/test_vsmove_unit.sv
module test_vsmove_unit;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN  = 32;
    localparam int FLEN  = 64;
    localparam int VLEN  = 256;
    localparam int NREGS = 8;
    localparam int IDX_W = $clog2(NREGS);
    localparam int VL_W  = $clog2(VLEN / 8) + 1;

    logic             clk = 1'b0;
    logic             rst_ni = 1'b0;
    logic             req_valid_i = 1'b0;
    logic [2:0]       op_i = '0;
    logic [1:0]       sew_i = '0;
    logic [VL_W-1:0]  vl_i = '0;
    logic [IDX_W-1:0] vd_i = '0;
    logic [XLEN-1:0]  rs1_i = '0;
    logic [FLEN-1:0]  fs1_i = '0;
    logic [IDX_W-1:0] rd_addr_i = '0;
    logic [VLEN-1:0]  rd_data_o;
    logic             done_o, use_vs1_o, use_vs2_o, use_rs1_o, use_fs1_o, is_scalar_o;

    vsmove_unit i_vsmove_unit (
        .clk_i       (clk),
        .rst_ni      (rst_ni),
        .req_valid_i (req_valid_i),
        .op_i        (op_i),
        .sew_i       (sew_i),
        .vl_i        (vl_i),
        .vd_i        (vd_i),
        .rs1_i       (rs1_i),
        .fs1_i       (fs1_i),
        .rd_addr_i   (rd_addr_i),
        .rd_data_o   (rd_data_o),
        .done_o      (done_o),
        .use_vs1_o   (use_vs1_o),
        .use_vs2_o   (use_vs2_o),
        .use_rs1_o   (use_rs1_o),
        .use_fs1_o   (use_fs1_o),
        .is_scalar_o (is_scalar_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        logic [4:0]      flags;   // {vs1, vs2, rs1, fs1, scalar}
        logic [VLEN-1:0] data;
        int              due;
        string           tag;
    } exp_t;

    exp_t            sb_q[$];
    logic [VLEN-1:0] model [NREGS];
    int              n_cmp = 0;
    int              n_bad = 0;
    int              cyc = 0;
    bit              run_done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [VLEN-1:0] act,
                         input logic [VLEN-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_flags(input logic [2:0] op);
        case (op)
            3'd0:    return 5'b11000;
            3'd2:    return 5'b00100;
            3'd3:    return 5'b00101;
            3'd4:    return 5'b00010;
            3'd5:    return 5'b00011;
            default: return 5'b00000;
        endcase
    endfunction

    function automatic logic [63:0] exp_elem(input logic [2:0] op, input logic [1:0] sew,
                                             input logic [XLEN-1:0] rs, input logic [FLEN-1:0] fs);
        logic [63:0] src;
        logic [63:0] keep;
        if (op == 3'd5) src = fs;
        else src = {{32{rs[31]}}, rs};
        keep = (sew == 2'd0) ? 64'hff : (sew == 2'd1) ? 64'hffff :
               (sew == 2'd2) ? 64'hffff_ffff : '1;
        return src & keep;
    endfunction

    task automatic issue(input logic [2:0] op, input logic [1:0] sew, input int vl,
                         input int vd, input logic [XLEN-1:0] rs, input logic [FLEN-1:0] fs,
                         input string tag);
        exp_t e;
        logic [63:0] keep;
        @(negedge clk);
        op_i = op; sew_i = sew; vl_i = VL_W'(vl); vd_i = IDX_W'(vd);
        rs1_i = rs; fs1_i = fs; rd_addr_i = IDX_W'(vd); req_valid_i = 1'b1;
        if ((op == 3'd3 || op == 3'd5) && vl != 0) begin
            keep = (sew == 2'd0) ? 64'hff : (sew == 2'd1) ? 64'hffff :
                   (sew == 2'd2) ? 64'hffff_ffff : '1;
            model[vd][63:0] = (model[vd][63:0] & ~keep) | exp_elem(op, sew, rs, fs);
        end
        e.flags = exp_flags(op);
        e.data  = model[vd];
        e.due   = cyc + 1;
        e.tag   = tag;
        sb_q.push_back(e);
        @(negedge clk);
        req_valid_i = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: compares each result in the cycle it is due
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_ni && !run_done) begin
                if (done_o) begin
                    if (sb_q.size() == 0) begin
                        check(1'b0, "R10 unexpected done", VLEN'(1), VLEN'(0));
                    end else begin
                        exp_t e;
                        logic [4:0] act_f;
                        e = sb_q.pop_front();
                        act_f = {use_vs1_o, use_vs2_o, use_rs1_o, use_fs1_o, is_scalar_o};
                        check(act_f == e.flags, {e.tag, " R7 R8 flags"}, VLEN'(act_f), VLEN'(e.flags));
                        check(rd_data_o == e.data, {e.tag, " data"}, rd_data_o, e.data);
                    end
                end else if (sb_q.size() != 0 && sb_q[0].due <= cyc) begin
                    check(1'b0, "R10 done missing", VLEN'(0), VLEN'(1));
                    void'(sb_q.pop_front());
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREGS; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        #1;
        // R12: reset state
        check(done_o == 1'b0, "R12 done after reset", VLEN'(done_o), VLEN'(0));
        check({use_vs1_o, use_vs2_o, use_rs1_o, use_fs1_o, is_scalar_o} == 5'b0,
              "R12 flags after reset",
              VLEN'({use_vs1_o, use_vs2_o, use_rs1_o, use_fs1_o, is_scalar_o}), VLEN'(0));
        for (int r = 0; r < NREGS; r++) begin
            rd_addr_i = IDX_W'(r);
            #1;
            check(rd_data_o == '0, "R12 register cleared", rd_data_o, '0);
        end

        // Integer scalar moves
        issue(3'd3, 2'd3, 16, 1, 32'hdeadbeef, '0, "R4 sext 0xdeadbeef");
        issue(3'd3, 2'd0, 16, 1, 32'h12345678, '0, "R1 R5 byte into e64 image");
        issue(3'd3, 2'd1, 16, 1, 32'hdeadbeef, '0, "R2 R5 halfword");
        issue(3'd3, 2'd2, 16, 2, 32'hdeadbeef, '0, "R3 word");
        issue(3'd3, 2'd3, 16, 6, 32'h7fffffff, '0, "R4 positive sext");
        issue(3'd3, 2'd0, 1, 6, 32'hdeadbeef, '0, "R1 R5 byte vl=1");

        // Floating-point scalar moves
        issue(3'd5, 2'd3, 16, 3, '0, 64'h3fed25da5d7296fe, "R6 fp e64");
        issue(3'd5, 2'd1, 16, 3, '0, 64'h00000000_0000bb81, "R6 fp e16");
        issue(3'd5, 2'd2, 16, 4, '0, 64'h12345678_bf75e762, "R6 fp e32 truncate");
        issue(3'd5, 2'd1, 16, 5, '0, 64'hffff_ffff_ffff_bb81, "R6 fp e16 truncate");

        // Zero vector length
        issue(3'd3, 2'd3, 0, 1, 32'h0badf00d, '0, "R9 vl zero int");
        issue(3'd5, 2'd3, 0, 3, '0, 64'h1111_2222_3333_4444, "R9 vl zero fp");

        // Forms that only decode
        issue(3'd0, 2'd3, 16, 2, 32'hffffffff, '1, "R7 R11 vv form");
        issue(3'd1, 2'd3, 16, 2, 32'hffffffff, '1, "R7 R11 vi form");
        issue(3'd2, 2'd3, 16, 2, 32'hffffffff, '1, "R7 R11 vx form");
        issue(3'd4, 2'd3, 16, 2, 32'hffffffff, '1, "R7 R11 vf form");
        issue(3'd6, 2'd3, 16, 2, 32'hffffffff, '1, "R8 R11 reserved 6");
        issue(3'd7, 2'd3, 16, 2, 32'hffffffff, '1, "R8 R11 reserved 7");

        // Back-to-back requests
        @(negedge clk);
        op_i = 3'd3; sew_i = 2'd0; vl_i = VL_W'(4); vd_i = IDX_W'(7); rd_addr_i = IDX_W'(7);
        rs1_i = 32'h000000a5; req_valid_i = 1'b1;
        model[7][7:0] = 8'ha5;
        sb_q.push_back('{flags: 5'b00101, data: model[7], due: cyc + 1, tag: "R10 back-to-back 1"});
        @(negedge clk);
        rs1_i = 32'h0000003c;
        model[7][7:0] = 8'h3c;
        sb_q.push_back('{flags: 5'b00101, data: model[7], due: cyc + 1, tag: "R10 back-to-back 2"});
        @(negedge clk);
        req_valid_i = 1'b0;
        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R10 all results delivered", VLEN'(sb_q.size()), VLEN'(0));

        // Final sweep of every register
        run_done = 1;
        for (int r = 0; r < NREGS; r++) begin
            rd_addr_i = IDX_W'(r);
            #1;
            check(rd_data_o == model[r], "R5 final register image", rd_data_o, model[r]);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule